// File: doc/BRIEF.md
# UART Transmit Chunk Sequencer

This block moves bytes from a circular transmit buffer into a small UART transmit FIFO. A producer advances the head pointer; the block owns the tail pointer. Whenever data is pending and no transfer is running, it plans one chunk. The chunk is either a byte-wise transfer of a few bytes, with the tail stepping once per byte, or a word-aligned burst that reads whole 32-bit words from the ring and feeds their bytes into the FIFO.

Short backlogs and misaligned tails go byte-wise. Larger backlogs that start on a word boundary go as bursts, so that bursts only ever start aligned and only ever carry whole words. A burst does not retire its bytes as they are written. The tail jumps forward by the burst length only after the line reports that both the holding stage and the output shifter are empty. A flush input abandons a burst without touching the tail. A FIFO trigger-level select output tells the surrounding UART which threshold suits the current chunk.

Top module: `uart_tx_chunk_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge): tail_ptr is 0, fifo_wr_en is 0, trig_burst is 0, and idle is 1 while head_ptr equals 0.
- R2: When fewer than BURST_MIN (16) bytes are pending, the chunk is byte-wise with length min(pending, FIFO_DEPTH). Its first byte is written only after fifo_level reads 0. Bytes are written on consecutive cycles in ring order, and tail_ptr advances by one for each byte written.
- R3: When at least 16 bytes are pending and tail_ptr is not a multiple of 4, a byte-wise chunk of exactly 4 − (tail_ptr mod 4) bytes is sent first.
- R4: When at least 16 bytes are pending and tail_ptr is a multiple of 4, a burst is sent. Its length is min(pending, ring size − tail_ptr), rounded down to a multiple of 4. Words are read at rd_addr with its low two bits zero. A byte at ring address a sits in rd_word bits [8·(a mod 4)+7 : 8·(a mod 4)], and the bytes of a word are written lowest lane first. A word is fetched only when fifo_level + 4 ≤ FIFO_DEPTH.
- R5: trig_burst is set when a chunk starts: 0 (FIFO-empty trigger) for a byte-wise chunk, 1 (four-byte trigger) for a burst. It holds that value until the next chunk starts.
- R6: During a burst, tail_ptr stays put until shift_empty and hold_empty are both 1 after the last byte. In that cycle it advances by the burst length, modulo the ring size.
- R7: No new chunk starts while one is in flight, even if head_ptr moves. When a chunk ends with data still pending, the next chunk starts without further stimulus.
- R8: idle is 1 exactly when head_ptr equals tail_ptr and no chunk is in flight.
- R9: A flush during a burst (fetching, writing or draining) stops it at once. No byte is written in the flush cycle or afterwards, tail_ptr is unchanged, and the block returns to its waiting state.
- R10: A flush during a byte-wise chunk has no effect; all of its bytes are written and retired.
- R11: If flush and the drained condition (both empty flags) arrive in the same cycle, flush wins and tail_ptr does not move.
- R12: The ring size is 2^ADDR_W, and tail_ptr wraps by discarding carries, so a burst ending at the ring top leaves tail_ptr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| head_ptr | input | ADDR_W | Producer write index into the ring |
| tail_ptr | output | ADDR_W | Oldest byte not yet retired |
| rd_addr | output | ADDR_W | Ring read address |
| rd_word | input | 32 | Ring word containing rd_addr, same cycle |
| fifo_wr_en | output | 1 | Push one byte into the transmit FIFO |
| fifo_wr_data | output | 8 | Byte pushed |
| fifo_level | input | clog2(FIFO_DEPTH+1) | Bytes currently in the FIFO |
| shift_empty | input | 1 | Output shifter has sent its last bit |
| hold_empty | input | 1 | Holding stage / FIFO is empty |
| flush | input | 1 | Abandon an in-flight burst |
| trig_burst | output | 1 | FIFO trigger select: 0 empty, 1 four bytes |
| idle | output | 1 | Ring empty and nothing in flight |

## Verification
Two events collide at the end of a burst. The drained condition, which retires the tail, can arrive in the same cycle as a flush, which abandons the burst. The bench provokes this by holding shift_empty low after a burst has fully left the FIFO. At one falling edge it then releases the flag, raises flush and empties the ring together. The result is judged by the tail staying at its pre-burst value with idle raised in the next cycle, and by no later movement or writes. A second overlap, head_ptr moving while a burst waits to drain, is judged by the absence of any new write until the drain completes.

// File: rtl/txseq_pkg.sv
// Shared definitions for the transmit chunk sequencer.
// Assumes a 32-bit ring read port, hence four byte lanes per word.
package txseq_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned LANE_W     = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYTE_WAIT,
        ST_BYTE_PUSH,
        ST_WORD_FETCH,
        ST_WORD_PUSH,
        ST_DRAIN
    } seq_state_t;
endpackage

// File: rtl/txseq_chunk_planner.sv
// Decides the next chunk from the ring pointers: byte-wise or burst, and
// its length. Purely combinational. Assumes the ring size is a power of
// two and a multiple of the word size, and that the producer keeps at most
// ring size - 1 bytes pending.
module txseq_chunk_planner
    import txseq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int BURST_MIN  = 16,
    localparam int LEN_W     = ADDR_W + 1,
    localparam int RING      = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] head,
    input  logic [ADDR_W-1:0] tail,
    output logic              have_data,
    output logic              use_burst,
    output logic [LEN_W-1:0]  chunk_len
);
    logic [ADDR_W-1:0] gap;
    logic [LEN_W-1:0]  pending;
    logic [LEN_W-1:0]  to_end;
    logic [LEN_W-1:0]  span;
    logic [LEN_W-1:0]  lead;
    logic              misaligned;

    // Distances measured from the tail: backlog, room to the ring top, lead-in.
    always_comb begin
        gap        = head - tail;
        pending    = LEN_W'(gap);
        to_end     = LEN_W'(RING) - LEN_W'(tail);
        span       = (pending < to_end) ? pending : to_end;
        misaligned = (tail[LANE_W-1:0] != '0);
        lead       = LEN_W'(WORD_BYTES) - LEN_W'(tail[LANE_W-1:0]);
    end

    // Mode choice; order matters: the short-backlog test comes first.
    always_comb begin
        have_data = (gap != '0);
        use_burst = 1'b0;
        if (pending < LEN_W'(BURST_MIN)) begin
            chunk_len = (pending < LEN_W'(FIFO_DEPTH)) ? pending : LEN_W'(FIFO_DEPTH);
        end else if (misaligned) begin
            chunk_len = lead;
        end else begin
            use_burst = 1'b1;
            chunk_len = span & ~LEN_W'(WORD_BYTES - 1);
        end
    end
endmodule

// File: rtl/txseq_word_unpack.sv
// Holds one ring word during a burst and presents its bytes lowest lane
// first. Assumes load and advance are never raised together.
module txseq_word_unpack
    import txseq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [8*WORD_BYTES-1:0] word_in,
    input  logic                    advance,
    output logic [7:0]              byte_out,
    output logic                    last_lane
);
    logic [8*WORD_BYTES-1:0] word_q;
    logic [LANE_W-1:0]       lane_q;

    // Capture a fresh word or step to the next lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            lane_q <= '0;
        end else if (load) begin
            word_q <= word_in;
            lane_q <= '0;
        end else if (advance) begin
            lane_q <= lane_q + 1'b1;
        end
    end

    // Lane select and end-of-word flag.
    always_comb begin
        byte_out  = word_q[8*lane_q +: 8];
        last_lane = (lane_q == LANE_W'(WORD_BYTES - 1));
    end
endmodule

// File: rtl/uart_tx_chunk_seq.sv
// Transmit chunk sequencer: drains a power-of-two byte ring into a UART
// transmit FIFO as byte-wise chunks or aligned word bursts. Assumes a
// same-cycle ring read port, a fifo_level input that counts bytes already
// pushed, and empty flags that stay low while any byte is still queued.
module uart_tx_chunk_seq
    import txseq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int BURST_MIN  = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       head_ptr,
    output logic [ADDR_W-1:0]       tail_ptr,
    output logic [ADDR_W-1:0]       rd_addr,
    input  logic [8*WORD_BYTES-1:0] rd_word,
    output logic                    fifo_wr_en,
    output logic [7:0]              fifo_wr_data,
    input  logic [LVL_W-1:0]        fifo_level,
    input  logic                    shift_empty,
    input  logic                    hold_empty,
    input  logic                    flush,
    output logic                    trig_burst,
    output logic                    idle
);
    localparam int LEN_W = ADDR_W + 1;
    localparam int IDX_W = ADDR_W - LANE_W;

    seq_state_t        state;
    logic [ADDR_W-1:0] tail_q;
    logic [IDX_W-1:0]  word_idx;
    logic [LEN_W-1:0]  burst_len;
    logic [LEN_W-1:0]  left;
    logic              trig_q;

    logic              plan_have;
    logic              plan_burst;
    logic [LEN_W-1:0]  plan_len;
    logic              room;
    logic              unpack_load;
    logic              unpack_adv;
    logic [7:0]        unpack_byte;
    logic              unpack_last;
    logic [7:0]        direct_byte;
    logic              drained;

    txseq_chunk_planner #(
        .ADDR_W     (ADDR_W),
        .FIFO_DEPTH (FIFO_DEPTH),
        .BURST_MIN  (BURST_MIN)
    ) u_plan (
        .head      (head_ptr),
        .tail      (tail_q),
        .have_data (plan_have),
        .use_burst (plan_burst),
        .chunk_len (plan_len)
    );

    txseq_word_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (unpack_load),
        .word_in   (rd_word),
        .advance   (unpack_adv),
        .byte_out  (unpack_byte),
        .last_lane (unpack_last)
    );

    // Handshake conditions seen by the controller.
    always_comb begin
        room        = (int'(fifo_level) + int'(WORD_BYTES)) <= FIFO_DEPTH;
        drained     = shift_empty && hold_empty;
        unpack_load = (state == ST_WORD_FETCH) && room && !flush;
        unpack_adv  = (state == ST_WORD_PUSH) && !flush;
        direct_byte = rd_word[8*tail_q[LANE_W-1:0] +: 8];
    end

    // Ring read address, FIFO write strobe and data, status outputs.
    always_comb begin
        rd_addr      = (state == ST_BYTE_PUSH) ? tail_q : {word_idx, LANE_W'(0)};
        fifo_wr_en   = (state == ST_BYTE_PUSH) || unpack_adv;
        fifo_wr_data = (state == ST_BYTE_PUSH) ? direct_byte : unpack_byte;
        tail_ptr     = tail_q;
        trig_burst   = trig_q;
        idle         = (state == ST_IDLE) && !plan_have;
    end

    // Chunk controller: plan, push, drain, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tail_q    <= '0;
            word_idx  <= '0;
            burst_len <= '0;
            left      <= '0;
            trig_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (plan_have) begin
                        trig_q <= plan_burst;
                        left   <= plan_len;
                        if (plan_burst) begin
                            burst_len <= plan_len;
                            word_idx  <= tail_q[ADDR_W-1:LANE_W];
                            state     <= ST_WORD_FETCH;
                        end else begin
                            state <= ST_BYTE_WAIT;
                        end
                    end
                end
                ST_BYTE_WAIT: begin
                    if (fifo_level == '0) state <= ST_BYTE_PUSH;
                end
                ST_BYTE_PUSH: begin
                    tail_q <= tail_q + 1'b1;
                    left   <= left - 1'b1;
                    if (left == LEN_W'(1)) state <= ST_IDLE;
                end
                ST_WORD_FETCH: begin
                    if (flush)     state <= ST_IDLE;
                    else if (room) state <= ST_WORD_PUSH;
                end
                ST_WORD_PUSH: begin
                    if (flush) begin
                        state <= ST_IDLE;
                    end else if (unpack_last) begin
                        word_idx <= word_idx + 1'b1;
                        left     <= left - LEN_W'(WORD_BYTES);
                        state    <= (left == LEN_W'(WORD_BYTES)) ? ST_DRAIN : ST_WORD_FETCH;
                    end
                end
                ST_DRAIN: begin
                    if (flush) begin
                        state <= ST_IDLE;
                    end else if (drained) begin
                        tail_q <= tail_q + ADDR_W'(burst_len);
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_chunk_seq_chk.sv
// Port-level checker for the transmit chunk sequencer, attached by bind.
module uart_tx_chunk_seq_chk #(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] head_ptr,
    input logic [ADDR_W-1:0] tail_ptr,
    input logic              fifo_wr_en,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              shift_empty,
    input logic              hold_empty,
    input logic              flush,
    input logic              trig_burst,
    input logic              idle
);
    // R4/R2: a push never lands on a full FIFO.
    assert_no_fifo_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (int'(fifo_level) < FIFO_DEPTH));

    // R2: a byte-wise run starts only on an empty FIFO.
    assert_byte_run_from_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && !trig_burst && !$past(fifo_wr_en)) |-> (fifo_level == '0));

    // R2: outside bursts the tail moves one step, and only with a write.
    assert_byte_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tail_ptr) && !$past(trig_burst)) |->
            ($past(fifo_wr_en) && (tail_ptr == ADDR_W'($past(tail_ptr) + 1'b1))));

    // R6: a burst tail move needs both empty flags and no flush.
    assert_burst_retire_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tail_ptr) && $past(trig_burst)) |->
            $past(shift_empty && hold_empty && !flush));

    // R8: idle only with an empty ring, and then nothing is written.
    assert_idle_means_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> ((head_ptr == tail_ptr) && !fifo_wr_en));

    // R9: after a flush during a burst, no byte follows.
    assert_flush_stops_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && trig_burst) |-> !fifo_wr_en);

    // R5: the trigger select never changes inside a write run.
    assert_trig_held_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && $past(fifo_wr_en)) |-> $stable(trig_burst));
endmodule

bind uart_tx_chunk_seq uart_tx_chunk_seq_chk #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_ptr    (head_ptr),
    .tail_ptr    (tail_ptr),
    .fifo_wr_en  (fifo_wr_en),
    .fifo_level  (fifo_level),
    .shift_empty (shift_empty),
    .hold_empty  (hold_empty),
    .flush       (flush),
    .trig_burst  (trig_burst),
    .idle        (idle)
);

// File: tb/uart_tx_chunk_seq_tb.sv
// Directed bench: a ring model, a FIFO-plus-shifter model and one task per scenario.
module uart_tx_chunk_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int RING       = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] head_ptr;
    logic [ADDR_W-1:0] tail_ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0]       rd_word;
    logic              fifo_wr_en;
    logic [7:0]        fifo_wr_data;
    logic [2:0]        lvl;
    logic              shift_empty;
    logic              hold_empty;
    logic              flush;
    logic              trig_burst;
    logic              idle;
    logic              hold_busy;

    logic [7:0] ring_mem [0:RING-1];
    int sh_cnt;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [7:0] log_b [0:1023];
    int nlog = 0;
    int run_len [0:255];
    bit run_trg [0:255];
    int nruns = 0;
    int cur_run = 0;
    bit cur_trg = 1'b0;

    int exp_len [0:31];
    bit exp_trg [0:31];
    int nexp = 0;
    int rbase = 0;
    int lbase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_chunk_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_ptr     (head_ptr),
        .tail_ptr     (tail_ptr),
        .rd_addr      (rd_addr),
        .rd_word      (rd_word),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .fifo_level   (lvl),
        .shift_empty  (shift_empty),
        .hold_empty   (hold_empty),
        .flush        (flush),
        .trig_burst   (trig_burst),
        .idle         (idle)
    );

    // Ring read port: the word holding rd_addr, lowest address in the low byte.
    logic [ADDR_W-1:0] wbase;
    assign wbase   = {rd_addr[ADDR_W-1:2], 2'b00};
    assign rd_word = {ring_mem[wbase | 6'd3], ring_mem[wbase | 6'd2],
                      ring_mem[wbase | 6'd1], ring_mem[wbase]};

    assign hold_empty  = (lvl == 3'd0);
    assign shift_empty = (lvl == 3'd0) && (sh_cnt == 0) && !hold_busy;

    // FIFO occupancy and a shifter that takes one byte every three cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            lvl    <= 3'd0;
            sh_cnt <= 0;
        end else begin
            automatic bit pop = (lvl != 3'd0) && (sh_cnt == 0);
            lvl    <= lvl + {2'b00, fifo_wr_en} - {2'b00, pop};
            sh_cnt <= pop ? 2 : ((sh_cnt > 0) ? sh_cnt - 1 : 0);
        end
    end

    // Write log and run-length record.
    always @(posedge clk) begin
        if (rst_n && fifo_wr_en) begin
            log_b[nlog] = fifo_wr_data;
            nlog        = nlog + 1;
            cur_run     = cur_run + 1;
            cur_trg     = trig_burst;
        end else if (cur_run > 0) begin
            run_len[nruns] = cur_run;
            run_trg[nruns] = cur_trg;
            nruns          = nruns + 1;
            cur_run        = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic begin_case();
        rbase = nruns;
        lbase = nlog;
        nexp  = 0;
    endtask

    task automatic want_run(input int len, input bit trg);
        exp_len[nexp] = len;
        exp_trg[nexp] = trg;
        nexp++;
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!idle && guard < 3000);
        @(negedge clk);
    endtask

    task automatic wait_log(input int target);
        int guard = 0;
        while (nlog < target && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_quiet();
        int guard = 0;
        while ((lvl != 3'd0 || sh_cnt != 0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_runs(input string tag);
        int bad = 0;
        for (int i = 0; i < nexp; i++) begin
            if (rbase + i >= nruns) bad++;
            else if (run_len[rbase+i] != exp_len[i] || run_trg[rbase+i] != exp_trg[i]) bad++;
        end
        chk((nruns - rbase == nexp) && bad == 0, tag, nruns - rbase, nexp);
    endtask

    task automatic check_data(input int start, input int n, input string tag);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (log_b[lbase+k] != ring_mem[(start + k) % RING]) bad++;
        end
        chk((nlog - lbase == n) && bad == 0, tag, nlog - lbase, n);
    endtask

    task automatic t_reset();
        chk(tail_ptr == '0, "R1 tail after reset", int'(tail_ptr), 0);
        chk(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
        chk(fifo_wr_en == 1'b0, "R1 no write after reset", int'(fifo_wr_en), 0);
        chk(trig_burst == 1'b0, "R1 trigger after reset", int'(trig_burst), 0);
    endtask

    // R2: 10 bytes from 0 go out as 4,4,2 byte-wise.
    task automatic t_small_bytes();
        begin_case();
        head_ptr = 6'd10;
        wait_idle();
        want_run(4, 0); want_run(4, 0); want_run(2, 0);
        check_runs("R2 byte chunk sizes");
        chk(tail_ptr == 6'd10, "R2 tail per byte", int'(tail_ptr), 10);
        check_data(0, 10, "R2 byte order");
    endtask

    // R3/R4/R5: tail 10, 30 pending: 2-byte lead-in, then a 28-byte burst.
    task automatic t_align_lead();
        begin_case();
        head_ptr = 6'd40;
        wait_idle();
        want_run(2, 0);
        for (int i = 0; i < 7; i++) want_run(4, 1);
        check_runs("R3 lead-in then R5 burst runs");
        chk(tail_ptr == 6'd40, "R4 tail after burst", int'(tail_ptr), 40);
        chk(trig_burst == 1'b1, "R5 trigger held after burst", int'(trig_burst), 1);
        check_data(10, 30, "R4 burst byte order");
    endtask

    // R4/R12: tail 40, 30 pending; burst stops at ring top, tail wraps.
    task automatic t_wrap_burst();
        begin_case();
        head_ptr = 6'd6;
        wait_idle();
        for (int i = 0; i < 6; i++) want_run(4, 1);
        want_run(4, 0); want_run(2, 0);
        check_runs("R4 burst clipped at ring end");
        chk(tail_ptr == 6'd6, "R12 tail wrapped", int'(tail_ptr), 6);
        check_data(40, 30, "R12 data across wrap");
    endtask

    // R6/R7/R8: burst waits for the shifter; head moves meanwhile.
    task automatic t_drain_gate();
        int n1;
        begin_case();
        hold_busy = 1'b1;
        head_ptr  = 6'd26;
        wait_log(lbase + 18);
        wait_quiet();
        chk(tail_ptr == 6'd8, "R6 tail held until drained", int'(tail_ptr), 8);
        chk(idle == 1'b0, "R8 not idle while in flight", int'(idle), 0);
        head_ptr = 6'd30;
        n1 = nlog;
        repeat (10) @(negedge clk);
        chk(nlog == n1, "R7 no new chunk in flight", nlog - n1, 0);
        hold_busy = 1'b0;
        @(negedge clk);
        chk(tail_ptr == 6'd24, "R6 tail retired on drain", int'(tail_ptr), 24);
        wait_idle();
        want_run(2, 0);
        for (int i = 0; i < 4; i++) want_run(4, 1);
        want_run(4, 0); want_run(2, 0);
        check_runs("R7 chunks resume automatically");
        chk(tail_ptr == 6'd30, "R7 tail reaches head", int'(tail_ptr), 30);
        chk(idle == 1'b1, "R8 idle at end", int'(idle), 1);
        check_data(6, 24, "R6 burst data");
    endtask

    // R10: flush held across a byte-wise chunk changes nothing.
    task automatic t_flush_bytes();
        begin_case();
        head_ptr = 6'd33;
        flush    = 1'b1;
        repeat (5) @(negedge clk);
        flush = 1'b0;
        wait_idle();
        chk(tail_ptr == 6'd33, "R10 byte chunk ignores flush", int'(tail_ptr), 33);
        check_data(30, 3, "R10 bytes still sent");
    endtask

    // R9: flush mid-burst with the ring emptied by the producer.
    task automatic t_flush_burst();
        int n1;
        begin_case();
        head_ptr = 6'd57;
        wait_log(lbase + 9);
        flush    = 1'b1;
        head_ptr = 6'd36;
        n1 = nlog;
        @(negedge clk);
        flush = 1'b0;
        chk(nlog == n1, "R9 no write in flush cycle", nlog - n1, 0);
        chk(tail_ptr == 6'd36, "R9 tail unchanged", int'(tail_ptr), 36);
        chk(idle == 1'b1, "R9 back to idle", int'(idle), 1);
        repeat (10) @(negedge clk);
        chk(nlog == n1, "R9 no later writes", nlog - n1, 0);
    endtask

    // R11: flush and drained condition in the same cycle.
    task automatic t_flush_vs_drain();
        int n1;
        begin_case();
        hold_busy = 1'b1;
        head_ptr  = 6'd52;
        wait_log(lbase + 16);
        wait_quiet();
        chk(tail_ptr == 6'd36, "R6 burst not retired yet", int'(tail_ptr), 36);
        hold_busy = 1'b0;
        flush     = 1'b1;
        head_ptr  = 6'd36;
        n1 = nlog;
        @(negedge clk);
        flush = 1'b0;
        chk(tail_ptr == 6'd36, "R11 flush beats retire", int'(tail_ptr), 36);
        chk(idle == 1'b1, "R11 idle after collision", int'(idle), 1);
        repeat (5) @(negedge clk);
        chk(tail_ptr == 6'd36 && nlog == n1, "R11 nothing afterwards", int'(tail_ptr), 36);
    endtask

    initial begin
        for (int i = 0; i < RING; i++) ring_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        rst_n     = 1'b0;
        head_ptr  = '0;
        flush     = 1'b0;
        hold_busy = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_bytes();
        t_align_lead();
        t_wrap_burst();
        t_drain_gate();
        t_flush_bytes();
        t_flush_burst();
        t_flush_vs_drain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule